// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects sixteen interrupt sources, ranks them by fixed priority, and presents one active-low request line to a processor. Every source has four bits of state: enable, pending, in-service and mask. A source raises its pending bit on a single-cycle event pulse only while it is enabled. A source drives the request line only while it is pending, enabled and unmasked, and only if no source of equal or higher rank is in service.

The processor answers the request with a one-cycle acknowledge strobe. During that cycle the block drives an 8-bit vector. The vector's upper nibble comes from a programmable vector register and its lower nibble is the winning channel number. A mode bit in the vector register selects the end-of-interrupt policy. In automatic mode the acknowledge only retires the pending bit. In software mode the acknowledge also marks the channel in service, and the channel stays in service until software clears it.

Software reaches the state through a byte-wide register bus. Writes take effect on the clock edge and reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_n_o` is 1. The register addresses are fixed as follows. Addresses 0 and 1 hold enable, 2 and 3 hold pending, 4 and 5 hold in-service, and 6 and 7 hold mask. Address 8 holds the vector register. Within each pair, the even address carries channels 15..8 (bit 7 = channel 15) and the odd address carries channels 7..0 (bit 7 = channel 7).
- R2: An event pulse on an enabled channel sets that channel's pending bit on the next clock edge.
- R3: An event on a channel whose enable bit is 0 leaves its pending bit at 0. Writing 0 to an enable bit also clears that channel's pending bit.
- R4: A channel with mask bit 0 still records pending, but it never pulls `irq_n_o` low.
- R5: `irq_n_o` is 0 exactly when some channel is enabled, pending and unmasked and ranks above every in-service channel. The highest channel number has the highest rank. While `irq_n_o` is 0, `vec_o` equals vector register bits 7:4 followed by the 4-bit number of the highest such channel.
- R6: With vector register bit 3 at 0 (automatic mode), an acknowledge clears the winning channel's pending bit and leaves in-service unchanged.
- R7: With vector register bit 3 at 1 (software mode), an acknowledge clears the winning channel's pending bit and sets its in-service bit.
- R8: While a channel is in service, pending channels of equal or lower number do not assert `irq_n_o`, but higher-numbered channels still do. Clearing the in-service bit releases the blocked channels.
- R9: A write to a pending or in-service register clears each bit written 0 and leaves unchanged each bit written 1. Such a write never sets a bit.
- R10: An acknowledge strobe while `irq_n_o` is 1 changes no state.
- R11: The vector register reads back the full byte last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Single-cycle event pulses, one bit per channel (bit n = channel n) |
| sel_i | input | 1 | Register bus cycle select |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| ack_i | input | 1 | One-cycle interrupt acknowledge strobe |
| vec_o | output | 8 | Vector of the current winner |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is software mode with nested service. This needs one channel in service, a second and lower channel pending behind it, a same-rank repeat pending, and a higher channel preempting. The stimulus builds that state step by step: it acknowledges one channel in software mode, then fires equal, lower and higher events. It then retires the in-service bits one at a time with clear-only writes. After each step it checks the request line, the vector and the register contents.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int NCH   = 16;
    localparam int IDXW  = $clog2(NCH);
    localparam int BYTEW = 8;
    localparam int NBANK = NCH / BYTEW;

    typedef enum logic [3:0] {
        RA_ENA_HI = 4'd0,
        RA_ENA_LO = 4'd1,
        RA_PND_HI = 4'd2,
        RA_PND_LO = 4'd3,
        RA_SRV_HI = 4'd4,
        RA_SRV_LO = 4'd5,
        RA_MSK_HI = 4'd6,
        RA_MSK_LO = 4'd7,
        RA_VEC    = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic            found;
        logic [IDXW-1:0] idx;
    } top_hit_t;

    typedef struct packed {
        logic [NCH-1:0] we;
        logic [NCH-1:0] d;
    } bank_wr_t;

    // Highest set bit of a channel vector.
    function automatic top_hit_t top_bit(input logic [NCH-1:0] v);
        top_hit_t r;
        r.found = 1'b0;
        r.idx   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = IDXW'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_chan_bank.sv
module ipc_chan_bank
    import ipc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  bank_wr_t       ena_wr,
    input  bank_wr_t       msk_wr,
    input  bank_wr_t       pnd_wr,
    input  bank_wr_t       srv_wr,
    input  logic [NCH-1:0] ack_hit,
    input  logic           sei_mode,
    output logic [NCH-1:0] ena_q,
    output logic [NCH-1:0] msk_q,
    output logic [NCH-1:0] pnd_q,
    output logic [NCH-1:0] srv_q
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ena_n, msk_n, pnd_n, srv_n;
        logic pnd_wclr, srv_wclr;

        always_comb begin
            pnd_wclr = pnd_wr.we[c] & ~pnd_wr.d[c];
            srv_wclr = srv_wr.we[c] & ~srv_wr.d[c];
            ena_n    = ena_wr.we[c] ? ena_wr.d[c] : ena_q[c];
            msk_n    = msk_wr.we[c] ? msk_wr.d[c] : msk_q[c];
            pnd_n    = ((pnd_q[c] & ~pnd_wclr & ~ack_hit[c])
                        | (evt[c] & ena_q[c])) & ena_n;
            srv_n    = (srv_q[c] & ~srv_wclr) | (ack_hit[c] & sei_mode);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ena_q[c] <= 1'b0;
                msk_q[c] <= 1'b0;
                pnd_q[c] <= 1'b0;
                srv_q[c] <= 1'b0;
            end else begin
                ena_q[c] <= ena_n;
                msk_q[c] <= msk_n;
                pnd_q[c] <= pnd_n;
                srv_q[c] <= srv_n;
            end
        end
    end

endmodule

// File: rtl/ipc_prio_sel.sv
module ipc_prio_sel
    import ipc_pkg::*;
(
    input  logic [NCH-1:0]  req,
    input  logic [NCH-1:0]  srv,
    output logic            active,
    output logic [IDXW-1:0] win_idx
);

    top_hit_t req_top, srv_top;

    always_comb begin
        req_top = top_bit(req);
        srv_top = top_bit(srv);
        win_idx = req_top.idx;
        active  = req_top.found &&
                  (!srv_top.found || (req_top.idx > srv_top.idx));
    end

endmodule

// File: rtl/ipc_bus_if.sv
module ipc_bus_if
    import ipc_pkg::*;
(
    input  logic             sel,
    input  logic             wr,
    input  logic [3:0]       addr,
    input  logic [BYTEW-1:0] wdata,
    input  logic [NCH-1:0]   ena_q,
    input  logic [NCH-1:0]   msk_q,
    input  logic [NCH-1:0]   pnd_q,
    input  logic [NCH-1:0]   srv_q,
    input  logic [BYTEW-1:0] vec_q,
    output bank_wr_t         ena_wr,
    output bank_wr_t         msk_wr,
    output bank_wr_t         pnd_wr,
    output bank_wr_t         srv_wr,
    output logic             vec_we,
    output logic [BYTEW-1:0] rdata
);

    logic wr_cyc;
    logic [NCH-1:0] wd_wide;

    function automatic logic [NCH-1:0] bank_sel(input logic [3:0] a,
                                                input reg_addr_e hi);
        logic [NCH-1:0] m;
        m = '0;
        if (a == hi)                m[NCH-1 -: BYTEW] = '1;
        if (a == 4'(int'(hi) + 1))  m[BYTEW-1:0]      = '1;
        return m;
    endfunction

    always_comb begin
        wr_cyc    = sel & wr;
        wd_wide   = {NBANK{wdata}};
        ena_wr.d  = wd_wide;
        msk_wr.d  = wd_wide;
        pnd_wr.d  = wd_wide;
        srv_wr.d  = wd_wide;
        ena_wr.we = wr_cyc ? bank_sel(addr, RA_ENA_HI) : '0;
        msk_wr.we = wr_cyc ? bank_sel(addr, RA_MSK_HI) : '0;
        pnd_wr.we = wr_cyc ? bank_sel(addr, RA_PND_HI) : '0;
        srv_wr.we = wr_cyc ? bank_sel(addr, RA_SRV_HI) : '0;
        vec_we    = wr_cyc && (addr == RA_VEC);
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            case (addr)
                RA_ENA_HI: rdata = ena_q[NCH-1 -: BYTEW];
                RA_ENA_LO: rdata = ena_q[BYTEW-1:0];
                RA_PND_HI: rdata = pnd_q[NCH-1 -: BYTEW];
                RA_PND_LO: rdata = pnd_q[BYTEW-1:0];
                RA_SRV_HI: rdata = srv_q[NCH-1 -: BYTEW];
                RA_SRV_LO: rdata = srv_q[BYTEW-1:0];
                RA_MSK_HI: rdata = msk_q[NCH-1 -: BYTEW];
                RA_MSK_LO: rdata = msk_q[BYTEW-1:0];
                RA_VEC:    rdata = vec_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import ipc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   evt_i,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [3:0]       addr_i,
    input  logic [BYTEW-1:0] wdata_i,
    output logic [BYTEW-1:0] rdata_o,
    input  logic             ack_i,
    output logic [BYTEW-1:0] vec_o,
    output logic             irq_n_o
);

    localparam int SEI_BIT = 3;

    bank_wr_t         ena_wr, msk_wr, pnd_wr, srv_wr;
    logic             vec_we;
    logic [BYTEW-1:0] vec_q;
    logic [NCH-1:0]   ena_q, msk_q, pnd_q, srv_q;
    logic [NCH-1:0]   req, ack_hit;
    logic             active;
    logic [IDXW-1:0]  win_idx;

    ipc_bus_if u_bus (
        .sel    (sel_i),
        .wr     (wr_i),
        .addr   (addr_i),
        .wdata  (wdata_i),
        .ena_q  (ena_q),
        .msk_q  (msk_q),
        .pnd_q  (pnd_q),
        .srv_q  (srv_q),
        .vec_q  (vec_q),
        .ena_wr (ena_wr),
        .msk_wr (msk_wr),
        .pnd_wr (pnd_wr),
        .srv_wr (srv_wr),
        .vec_we (vec_we),
        .rdata  (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst)         vec_q <= '0;
        else if (vec_we) vec_q <= wdata_i;
    end

    assign req = pnd_q & msk_q & ena_q;

    ipc_prio_sel u_sel (
        .req     (req),
        .srv     (srv_q),
        .active  (active),
        .win_idx (win_idx)
    );

    always_comb begin
        ack_hit = '0;
        if (ack_i && active) ack_hit[win_idx] = 1'b1;
    end

    ipc_chan_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_i),
        .ena_wr   (ena_wr),
        .msk_wr   (msk_wr),
        .pnd_wr   (pnd_wr),
        .srv_wr   (srv_wr),
        .ack_hit  (ack_hit),
        .sei_mode (vec_q[SEI_BIT]),
        .ena_q    (ena_q),
        .msk_q    (msk_q),
        .pnd_q    (pnd_q),
        .srv_q    (srv_q)
    );

    assign vec_o   = {vec_q[BYTEW-1:IDXW], win_idx};
    assign irq_n_o = ~active;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   evt_i,
    input logic             sel_i,
    input logic             wr_i,
    input logic             ack_i,
    input logic [BYTEW-1:0] vec_o,
    input logic             irq_n_o,
    input logic [NCH-1:0]   ena_q,
    input logic [NCH-1:0]   msk_q,
    input logic [NCH-1:0]   pnd_q,
    input logic [NCH-1:0]   srv_q,
    input logic [BYTEW-1:0] vec_q
);

    // R3: a disabled channel never holds pending
    a_r3_disabled_no_pend: assert property (@(posedge clk) disable iff (rst)
        (pnd_q & ~ena_q) == '0);

    // R4: the request line only names a channel that is unmasked and pending
    a_r4_mask_gate: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> (msk_q[vec_o[IDXW-1:0]] && pnd_q[vec_o[IDXW-1:0]]));

    // R5: the vector's upper nibble follows the vector register
    a_r5_vec_upper: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> (vec_o[BYTEW-1:IDXW] == vec_q[BYTEW-1:IDXW]));

    // R6: an automatic-mode acknowledge leaves in-service alone
    a_r6_aei_no_service: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_n_o && !vec_q[3] && !(sel_i && wr_i)) |=> $stable(srv_q));

    // R7: a software-mode acknowledge marks the winner in service
    a_r7_sei_sets_service: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_n_o && vec_q[3]) |=> srv_q[$past(vec_o[IDXW-1:0])]);

    // R6/R7: the acknowledged channel's pending is retired
    a_r7_ack_clears_pend: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_n_o && !evt_i[vec_o[IDXW-1:0]])
        |=> !pnd_q[$past(vec_o[IDXW-1:0])]);

    // R8: the winner always ranks above every in-service channel
    a_r8_service_blocks: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_o && srv_q != '0) |->
        ((srv_q >> vec_o[IDXW-1:0]) == '0));

    // R10: an acknowledge with no request changes no state
    a_r10_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_n_o && !sel_i && evt_i == '0)
        |=> ($stable(pnd_q) && $stable(srv_q)));

endmodule

bind prio_irq_ctrl ipc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (evt_i),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .ack_i   (ack_i),
    .vec_o   (vec_o),
    .irq_n_o (irq_n_o),
    .ena_q   (ena_q),
    .msk_q   (msk_q),
    .pnd_q   (pnd_q),
    .srv_q   (srv_q),
    .vec_q   (vec_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] evt_i;
    logic        sel_i, wr_i, ack_i;
    logic [3:0]  addr_i;
    logic [7:0]  wdata_i;
    logic [7:0]  rdata_o, vec_o;
    logic        irq_n_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i),
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .ack_i   (ack_i),
        .vec_o   (vec_o),
        .irq_n_o (irq_n_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; evt_i = '0; sel_i = 0; wr_i = 0; ack_i = 0; addr_i = '0; wdata_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk);
        sel_i = 0; wr_i = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        sel_i = 1; wr_i = 0; addr_i = a;
        #1 d = rdata_o;
        sel_i = 0;
    endtask

    task automatic fire(input logic [15:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk);
        v = vec_o;
        ack_i = 1;
        @(negedge clk);
        ack_i = 0;
    endtask

    task automatic open_all(input logic [7:0] vr);
        wr(4'd8, vr);
        wr(4'd0, 8'hFF); wr(4'd1, 8'hFF);
        wr(4'd6, 8'hFF); wr(4'd7, 8'hFF);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            check("R1 reg after reset", d, 8'h00);
        end
        check("R1 irq_n after reset", {7'd0, irq_n_o}, 8'h01);
    endtask

    task automatic t_enable_mask();
        logic [7:0] d;
        do_reset();
        wr(4'd1, 8'h01);
        fire(16'h0001);
        rd(4'd3, d); check("R2 pending set", d, 8'h01);
        check("R4 masked no irq", {7'd0, irq_n_o}, 8'h01);
        fire(16'h0002);
        rd(4'd3, d); check("R3 disabled ignored", d, 8'h01);
        wr(4'd7, 8'h01);
        @(negedge clk);
        check("R5 unmask irq", {7'd0, irq_n_o}, 8'h00);
        wr(4'd1, 8'h00);
        rd(4'd3, d); check("R3 disable clears pend", d, 8'h00);
        check("R3 irq released", {7'd0, irq_n_o}, 8'h01);
    endtask

    task automatic t_aei();
        logic [7:0] d, v;
        do_reset();
        open_all(8'hA0);
        rd(4'd8, d); check("R11 vec readback", d, 8'hA0);
        fire(16'h1008);
        @(negedge clk);
        check("R5 irq low", {7'd0, irq_n_o}, 8'h00);
        ack(v); check("R5 vector top", v, 8'hAC);
        rd(4'd2, d); check("R6 pend cleared", d, 8'h00);
        rd(4'd4, d); check("R6 srv hi untouched", d, 8'h00);
        ack(v); check("R5 vector next", v, 8'hA3);
        rd(4'd5, d); check("R6 srv lo untouched", d, 8'h00);
        check("R6 irq idle", {7'd0, irq_n_o}, 8'h01);
    endtask

    task automatic t_sei();
        logic [7:0] d, v;
        do_reset();
        open_all(8'h58);
        fire(16'h0020);
        ack(v); check("R5 vector ch5", v, 8'h55);
        rd(4'd5, d); check("R7 srv set", d, 8'h20);
        rd(4'd3, d); check("R7 pend cleared", d, 8'h00);
        fire(16'h0024);
        @(negedge clk);
        check("R8 equal/lower blocked", {7'd0, irq_n_o}, 8'h01);
        fire(16'h0200);
        @(negedge clk);
        check("R8 higher passes", {7'd0, irq_n_o}, 8'h00);
        ack(v); check("R8 vector ch9", v, 8'h59);
        rd(4'd4, d); check("R7 srv ch9", d, 8'h02);
        wr(4'd4, 8'hFF);
        rd(4'd4, d); check("R9 srv write one keeps", d, 8'h02);
        wr(4'd4, 8'hFD);
        rd(4'd4, d); check("R9 srv write zero clears", d, 8'h00);
        @(negedge clk);
        check("R8 still blocked by ch5", {7'd0, irq_n_o}, 8'h01);
        wr(4'd5, 8'h00);
        @(negedge clk);
        check("R8 released", {7'd0, irq_n_o}, 8'h00);
        check("R8 released vector", vec_o, 8'h55);
        wr(4'd3, 8'hFF);
        rd(4'd3, d); check("R9 pend write one keeps", d, 8'h24);
        wr(4'd3, 8'hDF);
        rd(4'd3, d); check("R9 pend write zero clears", d, 8'h04);
    endtask

    task automatic t_idle_ack();
        logic [7:0] d, v;
        do_reset();
        wr(4'd8, 8'h08);
        wr(4'd0, 8'h80);
        fire(16'h8000);
        check("R4 masked no irq", {7'd0, irq_n_o}, 8'h01);
        ack(v);
        rd(4'd2, d); check("R10 pend kept", d, 8'h80);
        rd(4'd4, d); check("R10 srv kept", d, 8'h00);
    endtask

    initial begin
        rst = 1'b1; evt_i = '0; sel_i = 0; wr_i = 0; ack_i = 0; addr_i = '0; wdata_i = '0;
        t_reset();
        t_enable_mask();
        t_aei();
        t_sei();
        t_idle_ack();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule